// File: doc/BRIEF.md
# Four-Core Local Interrupt Router

This block sits beside a cluster of four processor cores and decides which core, and which of its two interrupt inputs (normal IRQ or fast FIQ), each local interrupt source reaches. It takes four timer lines per core, four mailbox pending lines per core (mailbox storage lives in a neighbouring block), one interrupt line from the shared external interrupt controller, and one performance-monitor line per core. All inputs are level-sensitive.

Software programs routing through a small 32-bit register bus with address, write enable, write data and registered read data. Timer and mailbox sources are enabled per core through plain read/write configuration words. The shared external line is steered to exactly one core by a core-number field. The performance-monitor enables are changed through separate write-one-to-set and write-one-to-clear addresses, so cores never need a read-modify-write on a shared word. Each core has a read-only pending word that shows the raw level of every source that concerns it, in a fixed bit layout.

The control word and the timebase prescaler word are held here as plain storage for the counting logic elsewhere. That counting logic is not part of this block.

Top module: `lirq_router`

## Requirements
- R1: After synchronous reset, the control word (0x00), the shared routing word (0x0C), the monitor enable field (read at 0x10 or 0x14), every timer configuration word and every mailbox configuration word read 0. The prescaler word (0x08) reads 0x80000000, the nominal 19.2 MHz timebase setting. All `core_irq` and `core_fiq` bits are low.
- R2: The timer configuration word of core c is at 0x40+4c and stores write-data bits 7:0; bits 31:8 read 0. Bit i (0..3) enables timer i of core c (`tmr_lines[4c+i]`) onto `core_irq[c]`, and bit i+4 enables it onto `core_fiq[c]`.
- R3: The mailbox configuration word of core c is at 0x50+4c and has the same layout as in R2. It applies to the mailbox pending lines `mbx_pend[4c+i]`.
- R4: The pending word of core c at 0x60+4c reads as follows, whatever the enables are: bits 3:0 are `tmr_lines[4c+3:4c]`, bits 7:4 are `mbx_pend[4c+3:4c]`, bit 8 is `ext_line` when core c is the current recipient of the shared source (R6), and bit 9 is `pmu_lines[c]`. Bits 31:10 read 0.
- R5: Pending words are read-only. A write to 0x60..0x6C changes no pending bit and no configuration word.
- R6: The shared routing word at 0x0C stores bits 4:0 and reads 0 above them. Bits 1:0 name the IRQ target core and bits 3:2 name the FIQ target core. When bit 4 is 0, `ext_line` drives the IRQ of the IRQ target core. When bit 4 is 1, it drives the FIQ of the FIQ target core. No more than one core ever sees the shared source.
- R7: The monitor enable field has 8 bits. Bit c is the IRQ enable of `pmu_lines[c]` for core c, and bit c+4 is its FIQ enable. Writing 1s to 0x10 sets those bits and writing 1s to 0x14 clears them. Bits written as 0 keep their value. Both addresses read the field in bits 7:0.
- R8: `core_irq[c]` is the OR of all of core c's pending sources whose IRQ enable is set. `core_fiq[c]` is the same with FIQ enables. Both are registered, so they follow input and configuration changes one clock edge later.
- R9: The control word (0x00) and the prescaler word (0x08) store and read back all 32 bits.
- R10: Reads of unmapped offsets, including any address with bits 1:0 non-zero or any address at 0x70 and above, return 0. Writes to unmapped offsets change nothing.
- R11: Read data is registered. `bus_rdata` shows the word addressed at a clock edge from that edge onward, and a write is visible to a read addressed on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the register access |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tmr_lines | input | NCORE*4 (16) | Timer lines, four per core, core c at bits 4c+3:4c |
| mbx_pend | input | NCORE*4 (16) | Mailbox pending lines, four per core |
| ext_line | input | 1 | Shared external controller interrupt |
| pmu_lines | input | NCORE (4) | Performance-monitor line per core |
| core_irq | output | NCORE (4) | Registered IRQ request per core |
| core_fiq | output | NCORE (4) | Registered FIQ request per core |

## Verification
Directed cases set an enable on one core and drive a line on another, so a routing that ignores the core index shows up. They also set IRQ and FIQ enables on neighbouring bits, which catches swapped halves of a configuration word. The shared source is moved between cores and between delivery modes, and pending reads confirm that only the recipient reports bit 8. Monitor enables go through sequences of overlapping set and clear writes, which show up any write that overwrites the field instead of merging into it. Random rounds then mix configuration writes with random line levels, and every output and a pending word are compared against a model built from the requirements.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NSRC   = 4;          // sources per group per core
  localparam int unsigned CFG_W  = 2 * NSRC;   // IRQ half then FIQ half

  // Register offsets
  localparam int unsigned OFS_CTRL  = 'h00;
  localparam int unsigned OFS_PRESC = 'h08;
  localparam int unsigned OFS_SHR   = 'h0C;
  localparam int unsigned OFS_PMSET = 'h10;
  localparam int unsigned OFS_PMCLR = 'h14;
  localparam int unsigned OFS_TCFG  = 'h40;
  localparam int unsigned OFS_MCFG  = 'h50;
  localparam int unsigned OFS_PEND  = 'h60;
  localparam int unsigned OFS_TOP   = 'h70;

  localparam logic [DATA_W-1:0] PRESC_RESET = 32'h8000_0000;

  // Pending word bit positions
  localparam int unsigned PB_TMR = 0;
  localparam int unsigned PB_MBX = 4;
  localparam int unsigned PB_EXT = 8;
  localparam int unsigned PB_PMU = 9;

  typedef struct packed {
    logic       fiq_mode;
    logic [1:0] fiq_core;
    logic [1:0] irq_core;
  } shr_route_t;
endpackage

// File: rtl/lirq_cfg_regs.sv
module lirq_cfg_regs
  import lirq_pkg::*;
#(
  parameter int unsigned NCORE  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ADDR_W-1:0]               addr,
  input  logic                            we,
  input  logic [DATA_W-1:0]               wdata,
  output logic [DATA_W-1:0]               ctrl_q,
  output logic [DATA_W-1:0]               presc_q,
  output shr_route_t                      route_q,
  output logic [2*NCORE-1:0]              pmu_en_q,
  output logic [NCORE-1:0][CFG_W-1:0]     tcfg_q,
  output logic [NCORE-1:0][CFG_W-1:0]     mcfg_q
);
  localparam int unsigned PMU_W = 2 * NCORE;
  localparam int unsigned RT_W  = $bits(shr_route_t);

  logic pend_hit;

  always_comb begin
    pend_hit = 1'b0;
    for (int c = 0; c < NCORE; c++)
      if (addr == ADDR_W'(OFS_PEND + 4 * c)) pend_hit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      presc_q  <= PRESC_RESET;
      route_q  <= '0;
      pmu_en_q <= '0;
      tcfg_q   <= '0;
      mcfg_q   <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(OFS_CTRL))  ctrl_q  <= wdata;
      if (addr == ADDR_W'(OFS_PRESC)) presc_q <= wdata;
      if (addr == ADDR_W'(OFS_SHR))   route_q <= shr_route_t'(wdata[RT_W-1:0]);
      if (addr == ADDR_W'(OFS_PMSET)) pmu_en_q <= pmu_en_q | wdata[PMU_W-1:0];
      if (addr == ADDR_W'(OFS_PMCLR)) pmu_en_q <= pmu_en_q & ~wdata[PMU_W-1:0];
      for (int c = 0; c < NCORE; c++) begin
        if (addr == ADDR_W'(OFS_TCFG + 4 * c)) tcfg_q[c] <= wdata[CFG_W-1:0];
        if (addr == ADDR_W'(OFS_MCFG + 4 * c)) mcfg_q[c] <= wdata[CFG_W-1:0];
      end
    end
  end

  // R7: set address raises every bit written as 1
  assert_pmu_set_R7: assert property (@(posedge clk) disable iff (rst)
    (we && addr == ADDR_W'(OFS_PMSET)) |=>
      ((pmu_en_q & $past(wdata[PMU_W-1:0])) == $past(wdata[PMU_W-1:0])));

  // R7: clear address drops written bits and keeps the rest
  assert_pmu_clr_R7: assert property (@(posedge clk) disable iff (rst)
    (we && addr == ADDR_W'(OFS_PMCLR)) |=>
      ((pmu_en_q & $past(wdata[PMU_W-1:0])) == '0 &&
       (pmu_en_q & ~$past(wdata[PMU_W-1:0])) == ($past(pmu_en_q) & ~$past(wdata[PMU_W-1:0]))));

  // R5: a write aimed at a pending word disturbs no stored state
  assert_pend_write_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (we && pend_hit) |=> ($stable(tcfg_q) && $stable(mcfg_q) && $stable(pmu_en_q) &&
                          $stable(route_q) && $stable(ctrl_q) && $stable(presc_q)));
endmodule

// File: rtl/lirq_core_route.sv
module lirq_core_route
  import lirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   tmr,
  input  logic [NSRC-1:0]   mbx,
  input  logic              ext_irq,
  input  logic              ext_fiq,
  input  logic              pmu,
  input  logic [CFG_W-1:0]  tcfg,
  input  logic [CFG_W-1:0]  mcfg,
  input  logic              pmu_irq_en,
  input  logic              pmu_fiq_en,
  output logic [DATA_W-1:0] pend,
  output logic              irq_q,
  output logic              fiq_q
);
  localparam int unsigned PEND_USED = PB_PMU + 1;

  logic irq_d, fiq_d;

  always_comb begin
    pend = '0;
    pend[PB_TMR +: NSRC] = tmr;
    pend[PB_MBX +: NSRC] = mbx;
    pend[PB_EXT]         = ext_irq | ext_fiq;
    pend[PB_PMU]         = pmu;
  end

  always_comb begin
    irq_d = (|(tmr & tcfg[NSRC-1:0])) | (|(mbx & mcfg[NSRC-1:0])) |
            ext_irq | (pmu & pmu_irq_en);
    fiq_d = (|(tmr & tcfg[CFG_W-1:NSRC])) | (|(mbx & mcfg[CFG_W-1:NSRC])) |
            ext_fiq | (pmu & pmu_fiq_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      fiq_q <= fiq_d;
    end
  end

  // R8: a core with nothing pending is silent on the next edge
  assert_quiet_core_R8: assert property (@(posedge clk) disable iff (rst)
    (pend[PEND_USED-1:0] == '0) |=> (!irq_q && !fiq_q));
endmodule

// File: rtl/lirq_readback.sv
module lirq_readback
  import lirq_pkg::*;
#(
  parameter int unsigned NCORE  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             ctrl,
  input  logic [DATA_W-1:0]             presc,
  input  shr_route_t                    route,
  input  logic [2*NCORE-1:0]            pmu_en,
  input  logic [NCORE-1:0][CFG_W-1:0]   tcfg,
  input  logic [NCORE-1:0][CFG_W-1:0]   mcfg,
  input  logic [NCORE-1:0][DATA_W-1:0]  pend,
  output logic [DATA_W-1:0]             rdata_q
);
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    if (addr == ADDR_W'(OFS_CTRL))  rd_d = ctrl;
    if (addr == ADDR_W'(OFS_PRESC)) rd_d = presc;
    if (addr == ADDR_W'(OFS_SHR))   rd_d = DATA_W'(route);
    if (addr == ADDR_W'(OFS_PMSET) || addr == ADDR_W'(OFS_PMCLR)) rd_d = DATA_W'(pmu_en);
    for (int c = 0; c < NCORE; c++) begin
      if (addr == ADDR_W'(OFS_TCFG + 4 * c)) rd_d = DATA_W'(tcfg[c]);
      if (addr == ADDR_W'(OFS_MCFG + 4 * c)) rd_d = DATA_W'(mcfg[c]);
      if (addr == ADDR_W'(OFS_PEND + 4 * c)) rd_d = pend[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_d;
  end

  // R10: misaligned offsets read as zero
  assert_misaligned_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (addr[1:0] != 2'b00) |=> (rdata_q == '0));

  // R10: offsets past the last pending word read as zero
  assert_high_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (addr >= ADDR_W'(OFS_TOP)) |=> (rdata_q == '0));
endmodule

// File: rtl/lirq_router.sv
module lirq_router
  import lirq_pkg::*;
#(
  parameter int unsigned NCORE  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_we,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [NCORE*NSRC-1:0]   tmr_lines,
  input  logic [NCORE*NSRC-1:0]   mbx_pend,
  input  logic                    ext_line,
  input  logic [NCORE-1:0]        pmu_lines,
  output logic [NCORE-1:0]        core_irq,
  output logic [NCORE-1:0]        core_fiq
);
  logic [DATA_W-1:0]             ctrl_q, presc_q;
  shr_route_t                    route_q;
  logic [2*NCORE-1:0]            pmu_en_q;
  logic [NCORE-1:0][CFG_W-1:0]   tcfg_q, mcfg_q;
  logic [NCORE-1:0][DATA_W-1:0]  pend;
  logic [NCORE-1:0]              ext_irq_c, ext_fiq_c, ext_seen;

  lirq_cfg_regs #(.NCORE(NCORE), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .ctrl_q(ctrl_q), .presc_q(presc_q), .route_q(route_q), .pmu_en_q(pmu_en_q),
    .tcfg_q(tcfg_q), .mcfg_q(mcfg_q)
  );

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    assign ext_irq_c[c] = ext_line && !route_q.fiq_mode && (route_q.irq_core == 2'(c));
    assign ext_fiq_c[c] = ext_line &&  route_q.fiq_mode && (route_q.fiq_core == 2'(c));
    assign ext_seen[c]  = pend[c][PB_EXT];

    lirq_core_route u_route (
      .clk(clk), .rst(rst),
      .tmr(tmr_lines[c*NSRC +: NSRC]), .mbx(mbx_pend[c*NSRC +: NSRC]),
      .ext_irq(ext_irq_c[c]), .ext_fiq(ext_fiq_c[c]), .pmu(pmu_lines[c]),
      .tcfg(tcfg_q[c]), .mcfg(mcfg_q[c]),
      .pmu_irq_en(pmu_en_q[c]), .pmu_fiq_en(pmu_en_q[c + NCORE]),
      .pend(pend[c]), .irq_q(core_irq[c]), .fiq_q(core_fiq[c])
    );
  end

  lirq_readback #(.NCORE(NCORE), .ADDR_W(ADDR_W)) u_rb (
    .clk(clk), .rst(rst), .addr(bus_addr),
    .ctrl(ctrl_q), .presc(presc_q), .route(route_q), .pmu_en(pmu_en_q),
    .tcfg(tcfg_q), .mcfg(mcfg_q), .pend(pend), .rdata_q(bus_rdata)
  );

  // R6: the shared source shows up at no more than one core
  assert_shared_single_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ext_seen));
endmodule

// File: tb/tb_lirq_router.sv
module tb_lirq_router;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] tmr_l = '0, mbx_l = '0;
  logic        ext_l = 1'b0;
  logic [3:0]  pmu_l = '0;
  logic [3:0]  core_irq, core_fiq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // Model of the configuration state
  logic [31:0] m_ctrl, m_presc;
  logic [4:0]  m_route;
  logic [7:0]  m_pmu;
  logic [7:0]  m_tcfg [NC];
  logic [7:0]  m_mcfg [NC];

  always #4 clk = ~clk;

  lirq_router dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_lines(tmr_l), .mbx_pend(mbx_l), .ext_line(ext_l), .pmu_lines(pmu_l),
    .core_irq(core_irq), .core_fiq(core_fiq)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic ext_irq_at(int c);
    return ext_l && !m_route[4] && (m_route[1:0] == 2'(c));
  endfunction
  function automatic logic ext_fiq_at(int c);
    return ext_l && m_route[4] && (m_route[3:2] == 2'(c));
  endfunction
  function automatic logic [31:0] exp_pend(int c);
    return {22'b0, pmu_l[c], ext_irq_at(c) | ext_fiq_at(c), mbx_l[4*c +: 4], tmr_l[4*c +: 4]};
  endfunction
  function automatic logic [3:0] exp_irq();
    logic [3:0] v;
    for (int c = 0; c < NC; c++)
      v[c] = |(tmr_l[4*c +: 4] & m_tcfg[c][3:0]) | |(mbx_l[4*c +: 4] & m_mcfg[c][3:0]) |
             ext_irq_at(c) | (pmu_l[c] & m_pmu[c]);
    return v;
  endfunction
  function automatic logic [3:0] exp_fiq();
    logic [3:0] v;
    for (int c = 0; c < NC; c++)
      v[c] = |(tmr_l[4*c +: 4] & m_tcfg[c][7:4]) | |(mbx_l[4*c +: 4] & m_mcfg[c][7:4]) |
             ext_fiq_at(c) | (pmu_l[c] & m_pmu[c+4]);
    return v;
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (a == 8'h00) m_ctrl = d;
    if (a == 8'h08) m_presc = d;
    if (a == 8'h0C) m_route = d[4:0];
    if (a == 8'h10) m_pmu = m_pmu | d[7:0];
    if (a == 8'h14) m_pmu = m_pmu & ~d[7:0];
    for (int c = 0; c < NC; c++) begin
      if (a == 8'(8'h40 + 4*c)) m_tcfg[c] = d[7:0];
      if (a == 8'(8'h50 + 4*c)) m_mcfg[c] = d[7:0];
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic out_chk(string tag);
    @(negedge clk);
    check({tag, " irq"}, {28'b0, core_irq}, {28'b0, exp_irq()});
    check({tag, " fiq"}, {28'b0, core_fiq}, {28'b0, exp_fiq()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    m_ctrl = '0; m_presc = 32'h8000_0000; m_route = '0; m_pmu = '0;
    for (int c = 0; c < NC; c++) begin m_tcfg[c] = '0; m_mcfg[c] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 irq", {28'b0, core_irq}, 32'h0);
    check("R1 fiq", {28'b0, core_fiq}, 32'h0);
    rd_chk("R1 ctrl", 8'h00, 32'h0);
    rd_chk("R1 presc", 8'h08, 32'h8000_0000);
    rd_chk("R1 route", 8'h0C, 32'h0);
    rd_chk("R1 pmu", 8'h14, 32'h0);
    for (int c = 0; c < NC; c++) begin
      rd_chk("R1 tcfg", 8'(8'h40 + 4*c), 32'h0);
      rd_chk("R1 mcfg", 8'(8'h50 + 4*c), 32'h0);
    end

    // R2: core 1 timer 0 on IRQ, timer 1 on FIQ; upper write bits dropped
    wr(8'h44, 32'hFFFF_FF21);
    rd_chk("R2 tcfg readback", 8'h44, 32'h21);
    tmr_l = 16'h0010;                    // core 1 timer 0
    out_chk("R2 t0 irq only");
    tmr_l = 16'h0020;                    // core 1 timer 1
    out_chk("R2 t1 fiq only");
    tmr_l = 16'h0001;                    // core 0 timer 0, not enabled
    out_chk("R2 other core silent");

    // R3: mailbox 2 of core 3 on FIQ
    wr(8'h5C, 32'h40);
    mbx_l = 16'h4000; tmr_l = '0;
    out_chk("R3 mbx fiq");
    rd_chk("R3 mcfg readback", 8'h5C, 32'h40);

    // R4: raw pending regardless of enables
    tmr_l = 16'hA5C3; mbx_l = 16'h3C96; pmu_l = 4'b0101;
    for (int c = 0; c < NC; c++) rd_chk("R4 pending", 8'(8'h60 + 4*c), exp_pend(c));

    // R5: pending writes have no effect
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h6C, 32'hFFFF_FFFF);
    rd_chk("R5 pending unchanged", 8'h60, exp_pend(0));
    rd_chk("R5 tcfg unchanged", 8'h44, 32'h21);
    rd_chk("R5 pmu unchanged", 8'h10, 32'h0);
    out_chk("R5 outputs");

    // R6: shared source steering
    tmr_l = '0; mbx_l = '0; pmu_l = '0; ext_l = 1'b1;
    wr(8'h0C, 32'hFFFF_FFEB);            // irq core 3, fiq core 2, IRQ mode
    rd_chk("R6 route readback", 8'h0C, 32'h0B);
    out_chk("R6 irq to core3");
    rd_chk("R6 pend core3", 8'h6C, 32'h100);
    rd_chk("R6 pend core0", 8'h60, 32'h0);
    wr(8'h0C, 32'h1B);
    out_chk("R6 fiq to core2");
    rd_chk("R6 pend core2", 8'h68, 32'h100);
    rd_chk("R6 pend core3 off", 8'h6C, 32'h0);
    ext_l = 1'b0;

    // R7: set/clear enables
    wr(8'h10, 32'h11);
    rd_chk("R7 set", 8'h10, 32'h11);
    wr(8'h10, 32'h80);
    rd_chk("R7 set merge", 8'h14, 32'h91);
    wr(8'h14, 32'h01);
    rd_chk("R7 clear", 8'h10, 32'h90);
    wr(8'h14, 32'h0);
    rd_chk("R7 zero clear", 8'h10, 32'h90);
    pmu_l = 4'b1001;
    out_chk("R7 pmu routing");
    pmu_l = '0;

    // R9: plain storage
    wr(8'h00, 32'hDEAD_BEEF);
    wr(8'h08, 32'h0123_4567);
    rd_chk("R9 ctrl", 8'h00, 32'hDEAD_BEEF);
    rd_chk("R9 presc", 8'h08, 32'h0123_4567);

    // R10: unmapped reads and writes
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h41, 32'hFF);
    rd_chk("R10 0x04", 8'h04, 32'h0);
    rd_chk("R10 0x41", 8'h41, 32'h0);
    rd_chk("R10 0x18", 8'h18, 32'h0);
    rd_chk("R10 0x70", 8'h70, 32'h0);
    rd_chk("R10 0xFC", 8'hFC, 32'h0);
    rd_chk("R10 tcfg kept", 8'h40, 32'h0);
    rd_chk("R10 ctrl kept", 8'h00, 32'hDEAD_BEEF);

    // R11: write then read on the next edge
    @(negedge clk);
    bus_addr = 8'h48; bus_we = 1'b1; bus_wdata = 32'h5A;
    @(negedge clk);
    bus_we = 1'b0; m_tcfg[2] = 8'h5A;
    @(negedge clk);
    check("R11 read after write", bus_rdata, 32'h5A);

    // R8/R4: random mix
    for (int it = 0; it < 400; it++) begin
      int k = $urandom_range(0, 5);
      int c = $urandom_range(0, 3);
      logic [31:0] v = $urandom();
      case (k)
        0: wr(8'(8'h40 + 4*c), v);
        1: wr(8'(8'h50 + 4*c), v);
        2: wr(8'h0C, v);
        3: wr(8'h10, v & 32'h0000_0011);
        4: wr(8'h14, v & 32'h0000_0022);
        default: ;
      endcase
      tmr_l = 16'($urandom() & $urandom());
      mbx_l = 16'($urandom() & $urandom());
      ext_l = 1'($urandom());
      pmu_l = 4'($urandom());
      out_chk("R8 random");
      rd_chk("R4 random pending", 8'(8'h60 + 4*c), exp_pend(c));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule